// File: doc/BRIEF.md
# Atomic Set/Clear/Toggle Register Bank

This block is a bank of 32-bit control registers for a memory-mapped clock and analog control space. Software reaches it over a simple valid/ready request bus that carries a byte address, write data and a write enable. A registered read response with an error flag follows each request. The 0x8000-byte address range holds two windows. The lower window, at byte offset 0, holds plain registers. The upper window, at byte offset 0x4000, holds aliased registers. Each aliased register sits in a group of four words. The base word takes ordinary writes, and the next three words set, clear or toggle bits in one access. Software can therefore change a single field without a read-modify-write sequence.

Each register has its own read-only mask, which guards bits against every kind of write, and its own reset value. Some aliased registers control PLLs. For these, a lock status bit is forced high at reset on top of the reset value. An access to a misaligned address, or to a word past the implemented registers, returns zero and changes nothing. The response reports it through the error flag.

The bus controller is a two-state machine. In `ST_IDLE` it holds `req_ready` high. When `req_valid` is seen, the transition IDLE→RESP accepts the request. Any write takes effect at that same edge, and the read word or error is captured. In `ST_RESP` it drives `rsp_valid` for one cycle with `req_ready` low. The transition RESP→IDLE is unconditional.

Top module: `atomic_regbank`

## Requirements
- R1: After reset, each register holds its reset parameter value. An aliased register whose locked flag is set also has bit 31 set. The defaults are: plain registers 0x0401167F, 0x00000010, 0x00018D00 and 0x00000079; aliased registers 0x80013063, 0x80001001, 0x1018101B and 0x00000000.
- R2: A write to a plain register, or to an aliased base word, gives new = (old & ro) | (wdata & ~ro). The read-only masks are 0x00000000, 0xFFFFFFFF, 0xFFFF0000 and 0x000000FF for the plain registers. They are 0x800000FF, 0xFFFF0000, 0x40404040 and 0x00000000 for the aliased registers.
- R3: A write to base+1 word (byte address bits [3:2] = 1) gives new = old | (wdata & ~ro).
- R4: A write to base+2 word (bits [3:2] = 2) gives new = old & ~(wdata & ~ro).
- R5: A write to base+3 word (bits [3:2] = 3) gives new = old ^ (wdata & ~ro).
- R6: A read of any of the three alias words returns the current value of its base register.
- R7: A register whose mask is all ones never changes under any write. A register whose mask is zero takes every written bit.
- R8: An access with byte address bits [1:0] not zero sets `rsp_err`, returns read data 0 and changes no register.
- R9: An access past the implemented registers sets `rsp_err`, returns 0 and changes no register. This covers a plain word index of N_PLAIN or more, and an alias group of N_ALIAS or more.
- R10: Byte address bit 14 selects the window. In the plain window the word index is bits [13:2]. In the alias window the group is bits [13:4] and the operation is bits [3:2].
- R11: `req_ready` is high in `ST_IDLE` and low in `ST_RESP`. `rsp_valid` rises for exactly one cycle in the cycle after a request is accepted. A write is visible to the very next request.
- R12: Every write response carries read data 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_addr | input | ADDR_W | Byte address within the 0x8000 range |
| req_we | input | 1 | 1 for write, 0 for read |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response present, one cycle per request |
| rsp_rdata | output | 32 | Read data (0 on writes and errors) |
| rsp_err | output | 1 | Misaligned or unimplemented address |

## Verification
The bench targets the masking on each write path. It sets, clears and toggles bits across an all-ones mask and across the lock bit. A design that applies the mask only to plain writes would lose the lock bit on a clear alias. Alias reads are compared with the base value after each change. A design that decodes the alias words as separate storage would return stale or zero data. Misaligned and out-of-range writes are each followed by a read-back of the register they would have hit. This catches a decoder that drops the low address bits or wraps the group index. A stream of mixed operations checks the result of every access against a model kept in the bench.

// File: rtl/atomic_regbank_pkg.sv
package atomic_regbank_pkg;

    localparam int WORD_W = 32;

    // Write operation selected by alias word offset within a group
    typedef enum logic [1:0] {
        OP_PLAIN = 2'd0,
        OP_SET   = 2'd1,
        OP_CLR   = 2'd2,
        OP_TOG   = 2'd3
    } wr_op_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } bus_state_e;

    // Next register value for one write; read-only bits are protected on every path
    function automatic logic [WORD_W-1:0] apply_op(
        input wr_op_e            op,
        input logic [WORD_W-1:0] cur,
        input logic [WORD_W-1:0] wdata,
        input logic [WORD_W-1:0] ro
    );
        logic [WORD_W-1:0] eff;
        eff = wdata & ~ro;
        unique case (op)
            OP_PLAIN: apply_op = (cur & ro) | eff;
            OP_SET:   apply_op = cur | eff;
            OP_CLR:   apply_op = cur & ~eff;
            OP_TOG:   apply_op = cur ^ eff;
            default:  apply_op = cur;
        endcase
    endfunction

endpackage

// File: rtl/arb_decode.sv
module arb_decode
    import atomic_regbank_pkg::*;
#(
    parameter int ADDR_W  = 15,
    parameter int N_PLAIN = 4,
    parameter int N_ALIAS = 4,
    parameter int IDX_W   = 3
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output logic [IDX_W-1:0]  idx,
    output wr_op_e            op
);
    // word index spans addr[ADDR_W-2:2]; the group drops the two op bits
    localparam int WIDX_W = ADDR_W - 3;
    localparam int GRP_W  = ADDR_W - 5;
    localparam logic [WIDX_W-1:0] PLAIN_LIM = WIDX_W'(N_PLAIN);
    localparam logic [GRP_W-1:0]  ALIAS_LIM = GRP_W'(N_ALIAS);

    logic              win_alias;
    logic [WIDX_W-1:0] word;
    logic [GRP_W-1:0]  grp;

    always_comb begin
        win_alias = addr[ADDR_W-1];
        word      = addr[ADDR_W-2:2];
        grp       = word[WIDX_W-1:2];
        hit       = 1'b0;
        idx       = '0;
        op        = OP_PLAIN;
        if (addr[1:0] == 2'b00) begin
            if (!win_alias) begin
                if (word < PLAIN_LIM) begin
                    hit = 1'b1;
                    idx = IDX_W'(word);
                end
            end else if (grp < ALIAS_LIM) begin
                hit = 1'b1;
                idx = IDX_W'(N_PLAIN) + IDX_W'(grp);
                op  = wr_op_e'(word[1:0]);
            end
        end
    end

endmodule

// File: rtl/arb_slot.sv
module arb_slot
    import atomic_regbank_pkg::*;
#(
    parameter logic [WORD_W-1:0] RST_VAL = '0,
    parameter logic [WORD_W-1:0] RO_MASK = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  wr_op_e            op,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= RST_VAL;
        end else if (wr_en) begin
            q <= apply_op(op, q, wdata, RO_MASK);
        end
    end

endmodule

// File: rtl/arb_fsm.sv
module arb_fsm
    import atomic_regbank_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_we,
    input  logic              hit,
    input  logic [WORD_W-1:0] rd_word,
    output logic              req_ready,
    output logic              accept,
    output logic              rsp_valid,
    output logic [WORD_W-1:0] rsp_rdata,
    output logic              rsp_err
);
    bus_state_e state, nxt;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt;
        end
    end

    // transitions: IDLE->RESP on a request, RESP->IDLE always
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: if (req_valid) nxt = ST_RESP;
            ST_RESP: nxt = ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
    end

    assign req_ready = (state == ST_IDLE);
    assign accept    = req_valid && req_ready;
    assign rsp_valid = (state == ST_RESP);

    // response capture at the accepting edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_rdata <= '0;
            rsp_err   <= 1'b0;
        end else if (accept) begin
            rsp_rdata <= (hit && !req_we) ? rd_word : '0;
            rsp_err   <= !hit;
        end
    end

endmodule

// File: rtl/atomic_regbank.sv
module atomic_regbank
    import atomic_regbank_pkg::*;
#(
    parameter int ADDR_W   = 15,
    parameter int N_PLAIN  = 4,
    parameter int N_ALIAS  = 4,
    parameter int LOCK_BIT = 31,
    parameter logic [N_PLAIN*WORD_W-1:0] PLAIN_RST =
        {32'h0000_0079, 32'h0001_8D00, 32'h0000_0010, 32'h0401_167F},
    parameter logic [N_PLAIN*WORD_W-1:0] PLAIN_RO =
        {32'h0000_00FF, 32'hFFFF_0000, 32'hFFFF_FFFF, 32'h0000_0000},
    parameter logic [N_ALIAS*WORD_W-1:0] ALIAS_RST =
        {32'h0000_0000, 32'h1018_101B, 32'h0000_1001, 32'h0001_3063},
    parameter logic [N_ALIAS*WORD_W-1:0] ALIAS_RO =
        {32'h0000_0000, 32'h4040_4040, 32'hFFFF_0000, 32'h8000_00FF},
    parameter logic [N_ALIAS-1:0] ALIAS_LOCKED = 4'b0011
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_we,
    input  logic [WORD_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [WORD_W-1:0] rsp_rdata,
    output logic              rsp_err
);
    localparam int N_REGS = N_PLAIN + N_ALIAS;
    localparam int IDX_W  = (N_REGS > 1) ? $clog2(N_REGS) : 1;
    localparam logic [WORD_W-1:0] LOCK_MASK = WORD_W'(1) << LOCK_BIT;
    localparam logic [N_REGS*WORD_W-1:0] RO_ALL = {ALIAS_RO, PLAIN_RO};

    logic              hit;
    logic [IDX_W-1:0]  idx;
    wr_op_e            op;
    logic              accept;
    logic [WORD_W-1:0] reg_q [N_REGS];
    logic [N_REGS*WORD_W-1:0] reg_flat;
    logic [WORD_W-1:0] rd_word;

    arb_decode #(
        .ADDR_W (ADDR_W),
        .N_PLAIN(N_PLAIN),
        .N_ALIAS(N_ALIAS),
        .IDX_W  (IDX_W)
    ) u_decode (
        .addr(req_addr),
        .hit (hit),
        .idx (idx),
        .op  (op)
    );

    generate
        for (genvar p = 0; p < N_PLAIN; p++) begin : g_plain
            arb_slot #(
                .RST_VAL(PLAIN_RST[p*WORD_W +: WORD_W]),
                .RO_MASK(PLAIN_RO[p*WORD_W +: WORD_W])
            ) u_slot (
                .clk  (clk),
                .rst_n(rst_n),
                .wr_en(accept && req_we && hit && (idx == IDX_W'(p))),
                .op   (OP_PLAIN),
                .wdata(req_wdata),
                .q    (reg_q[p])
            );
        end
        for (genvar g = 0; g < N_ALIAS; g++) begin : g_alias
            localparam logic [WORD_W-1:0] RV =
                ALIAS_RST[g*WORD_W +: WORD_W] | (ALIAS_LOCKED[g] ? LOCK_MASK : '0);
            arb_slot #(
                .RST_VAL(RV),
                .RO_MASK(ALIAS_RO[g*WORD_W +: WORD_W])
            ) u_slot (
                .clk  (clk),
                .rst_n(rst_n),
                .wr_en(accept && req_we && hit && (idx == IDX_W'(N_PLAIN + g))),
                .op   (op),
                .wdata(req_wdata),
                .q    (reg_q[N_PLAIN + g])
            );
        end
        for (genvar r = 0; r < N_REGS; r++) begin : g_flat
            assign reg_flat[r*WORD_W +: WORD_W] = reg_q[r];
        end
    endgenerate

    assign rd_word = reg_q[idx];

    arb_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_valid(req_valid),
        .req_we   (req_we),
        .hit      (hit),
        .rd_word  (rd_word),
        .req_ready(req_ready),
        .accept   (accept),
        .rsp_valid(rsp_valid),
        .rsp_rdata(rsp_rdata),
        .rsp_err  (rsp_err)
    );

endmodule

// File: rtl/atomic_regbank_chk.sv
module atomic_regbank_chk #(
    parameter int N_REGS = 8,
    parameter logic [N_REGS*32-1:0] RO_ALL = '0
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 req_valid,
    input logic                 req_ready,
    input logic                 req_we,
    input logic                 rsp_valid,
    input logic                 rsp_err,
    input logic [31:0]          rsp_rdata,
    input logic [N_REGS*32-1:0] reg_flat
);
    assert_rsp_after_accept_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> rsp_valid);

    assert_rsp_one_cycle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    assert_busy_not_ready_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !req_ready);

    assert_err_zero_data_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_err) |-> (rsp_rdata == 32'h0));

    assert_write_zero_data_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_we) |=> (rsp_rdata == 32'h0));

    generate
        for (genvar i = 0; i < N_REGS; i++) begin : g_ro
            // protected bits (lock bit included) never move after reset: R7, R2
            assert_ro_bits_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
                $stable(reg_flat[i*32 +: 32] & RO_ALL[i*32 +: 32]));
        end
    endgenerate

endmodule

bind atomic_regbank atomic_regbank_chk #(
    .N_REGS(N_REGS),
    .RO_ALL(RO_ALL)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .req_ready(req_ready),
    .req_we   (req_we),
    .rsp_valid(rsp_valid),
    .rsp_err  (rsp_err),
    .rsp_rdata(rsp_rdata),
    .reg_flat (reg_flat)
);

// File: tb/test_atomic_regbank.sv
module test_atomic_regbank;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [14:0] req_addr = '0;
    logic        req_we = 1'b0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic        rsp_err;

    always #(CLK_PERIOD/2) clk = ~clk;

    atomic_regbank i_atomic_regbank (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_we(req_we), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err)
    );

    typedef struct {
        logic [14:0] addr;
        logic [31:0] rdata;
        logic        err;
        string       tag;
    } exp_t;

    exp_t        sb[$];
    int          n_checks = 0;
    int          n_fail = 0;
    logic [31:0] mdl [8];
    logic [31:0] ro  [8];

    // bench-side model of the requirements
    function automatic void decode(input logic [14:0] a, output bit hit,
                                   output int idx, output int op);
        int word;
        hit = 0; idx = 0; op = 0;
        word = int'(a[13:2]);
        if (a[1:0] != 2'b00) return;
        if (!a[14]) begin
            if (word < 4) begin hit = 1; idx = word; end
        end else if ((word >> 2) < 4) begin
            hit = 1; idx = 4 + (word >> 2); op = word & 3;
        end
    endfunction

    task automatic xact(input logic [14:0] a, input logic we,
                        input logic [31:0] wd, input string tag);
        bit hit; int idx; int op;
        exp_t e;
        logic [31:0] eff;
        decode(a, hit, idx, op);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_we = we; req_wdata = wd;
        while (!req_ready) @(negedge clk);
        @(posedge clk);
        e.addr = a; e.err = !hit; e.tag = tag; e.rdata = 32'h0;
        if (hit && !we) e.rdata = mdl[idx];
        if (hit && we) begin
            eff = wd & ~ro[idx];
            case (op)
                0: mdl[idx] = (mdl[idx] & ro[idx]) | eff;
                1: mdl[idx] = mdl[idx] | eff;
                2: mdl[idx] = mdl[idx] & ~eff;
                default: mdl[idx] = mdl[idx] ^ eff;
            endcase
        end
        sb.push_back(e);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // monitor
    initial begin
        forever begin
            @(negedge clk);
            if (rsp_valid) begin
                n_checks++;
                if (sb.size() == 0) begin
                    n_fail++;
                    $display("FAIL R11 unexpected response rdata=%h err=%b exp=none",
                             rsp_rdata, rsp_err);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    if (rsp_rdata !== e.rdata || rsp_err !== e.err) begin
                        n_fail++;
                        $display("FAIL %s addr=%h rdata=%h exp=%h err=%b exp=%b",
                                 e.tag, e.addr, rsp_rdata, e.rdata, rsp_err, e.err);
                    end
                end
            end
        end
    end

    task automatic direct(input bit ok, input string tag, input logic [31:0] act,
                          input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    bit done = 0;

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] x;
        mdl[0] = 32'h0401_167F; ro[0] = 32'h0000_0000;
        mdl[1] = 32'h0000_0010; ro[1] = 32'hFFFF_FFFF;
        mdl[2] = 32'h0001_8D00; ro[2] = 32'hFFFF_0000;
        mdl[3] = 32'h0000_0079; ro[3] = 32'h0000_00FF;
        mdl[4] = 32'h8001_3063; ro[4] = 32'h8000_00FF;
        mdl[5] = 32'h8000_1001; ro[5] = 32'hFFFF_0000;
        mdl[6] = 32'h1018_101B; ro[6] = 32'h4040_4040;
        mdl[7] = 32'h0000_0000; ro[7] = 32'h0000_0000;

        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        direct(req_ready == 1'b1, "R11 ready after reset", 32'(req_ready), 32'h1);
        direct(rsp_valid == 1'b0, "R11 no response after reset", 32'(rsp_valid), 32'h0);

        // R1: reset values, lock bits on the PLL-type aliased registers
        for (int i = 0; i < 4; i++) xact(15'(i*4), 1'b0, 32'h0, "R1 plain reset");
        for (int g = 0; g < 4; g++) xact(15'(16'h4000 + g*16), 1'b0, 32'h0, "R1 alias reset/lock");

        // R6: alias words read back the base
        for (int o = 1; o < 4; o++) xact(15'(16'h4000 + o*4), 1'b0, 32'h0, "R6 alias read");

        // R2 / R7 plain writes, including all-ones and zero masks; R12 zero data on writes
        xact(15'h0000, 1'b1, 32'hDEAD_BEEF, "R12 write rdata");
        xact(15'h0000, 1'b0, 32'h0, "R7 zero mask fully writable");
        xact(15'h0004, 1'b1, 32'hA5A5_A5A5, "R7 write all-ones mask");
        xact(15'h0004, 1'b0, 32'h0, "R7 all-ones mask unchanged");
        xact(15'h0008, 1'b1, 32'h1234_5678, "R2 plain write");
        xact(15'h0008, 1'b0, 32'h0, "R2 masked plain write");
        xact(15'h000C, 1'b1, 32'hFFFF_FF00, "R2 plain write low ro");
        xact(15'h000C, 1'b0, 32'h0, "R2 low ro kept");
        xact(15'h4020, 1'b1, 32'hFFFF_FFFF, "R2 alias base write");
        xact(15'h4020, 1'b0, 32'h0, "R2 alias base masked");

        // R3/R4/R5 on the fully writable aliased register
        xact(15'h4034, 1'b1, 32'h0000_00F0, "R3 set");
        xact(15'h4030, 1'b0, 32'h0, "R3 set readback");
        xact(15'h4038, 1'b1, 32'h0000_0030, "R4 clear");
        xact(15'h403C, 1'b0, 32'h0, "R6 read via toggle alias");
        xact(15'h403C, 1'b1, 32'h0000_00FF, "R5 toggle");
        xact(15'h4030, 1'b0, 32'h0, "R5 toggle readback");

        // masks on alias paths: lock bit survives clear and toggle
        xact(15'h4004, 1'b1, 32'hFFFF_FFFF, "R3 masked set");
        xact(15'h4000, 1'b0, 32'h0, "R3 masked set readback");
        xact(15'h4008, 1'b1, 32'hFFFF_FFFF, "R4 clear keeps lock");
        xact(15'h4000, 1'b0, 32'h0, "R4 clear readback");
        xact(15'h400C, 1'b1, 32'hFFFF_FFFF, "R5 toggle keeps lock");
        xact(15'h4004, 1'b0, 32'h0, "R6 read via set alias");
        xact(15'h402C, 1'b1, 32'hFFFF_FFFF, "R5 toggle with scattered ro");
        xact(15'h4028, 1'b0, 32'h0, "R6 read via clear alias");
        xact(15'h401C, 1'b1, 32'h0000_FFFF, "R10 group 1 toggle address");
        xact(15'h4010, 1'b0, 32'h0, "R10 group 1 readback");

        // R8 misaligned accesses
        xact(15'h0001, 1'b1, 32'h0000_0000, "R8 misaligned write");
        xact(15'h0000, 1'b0, 32'h0, "R8 target unchanged");
        xact(15'h4032, 1'b0, 32'h0, "R8 misaligned read");
        xact(15'h4037, 1'b1, 32'hFFFF_FFFF, "R8 misaligned set");
        xact(15'h4030, 1'b0, 32'h0, "R8 alias target unchanged");

        // R9 out of range
        xact(15'h0010, 1'b1, 32'hFFFF_FFFF, "R9 plain beyond count write");
        xact(15'h0010, 1'b0, 32'h0, "R9 plain beyond count read");
        xact(15'h4040, 1'b1, 32'h0, "R9 alias group beyond count");
        xact(15'h4048, 1'b1, 32'hFFFF_FFFF, "R9 clear beyond count");
        xact(15'h3FFC, 1'b0, 32'h0, "R9 top of plain window");
        xact(15'h7FFC, 1'b0, 32'h0, "R9 top of alias window");
        for (int i = 0; i < 8; i++) begin
            xact((i < 4) ? 15'(i*4) : 15'(16'h4000 + (i-4)*16), 1'b0, 32'h0,
                 "R9 bank unchanged after bad accesses");
        end

        // mixed stream over the alias window
        x = 32'h1357_9BDF;
        for (int k = 0; k < 60; k++) begin
            x = x ^ (x << 13); x = x ^ (x >> 17); x = x ^ (x << 5);
            xact(15'(16'h4000 + (x[9:8] * 16) + (x[11:10] * 4)), x[12], x, "R10 mixed op");
        end
        for (int g = 0; g < 4; g++) xact(15'(16'h4000 + g*16), 1'b0, 32'h0, "R6 final state");

        repeat (4) @(negedge clk);
        direct(sb.size() == 0, "R11 all responses returned", 32'(sb.size()), 32'h0);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule